// File: doc/BRIEF.md
# Slot-Select Write Sequencer

This block sits on the host side of a three-wire serial link and writes one slot-select word to a backplane controller. The link carries an active-low frame strobe, a serial clock that idles high, and a data line. A write pulls the strobe low, shifts out the word most significant bit first with one rising clock edge per bit, then releases the strobe. Releasing the strobe is what commits the word at the far end.

Logic on the user side raises `start_i` for one cycle with the word on `word_i`. It can instead raise `zero_i` to write the all-zero word, which deselects every slot while the link is idle. The block reports `busy_o` for the whole frame and pulses `done_o` once the strobe is back high. Two gaps are held as minimum times: strobe fall to first rising clock edge, and last rising edge to strobe release. Both are given in picoseconds together with the system clock period, and the block rounds each one up to whole cycles. The clock low and high half-periods are cycle counts set by parameters.

Top module: `slot_select_writer`

## Requirements
- R1: After reset and whenever no frame is in progress, `strobe_n_o` and `sclk_o` are both 1, and `busy_o` and `done_o` are 0.
- R2: A request seen while idle drives `strobe_n_o` to 0 from the next cycle. The strobe stays low for exactly SETUP_CYC + WORD_W·(CLK_LO_CYC + CLK_HI_CYC) + HOLD_CYC cycles.
- R3: Each frame has exactly WORD_W (default 16) rising edges of `sclk_o`. Each low phase lasts CLK_LO_CYC cycles and each high phase lasts CLK_HI_CYC cycles.
- R4: Bits go out most significant first. `sdata_o` takes the next bit only in the cycle where `sclk_o` falls, so it is stable through every rising edge.
- R5: The number of cycles from the strobe falling to the first rising clock edge is at least SETUP_CYC = ceil(SETUP_PS / CLK_PS), with a minimum of 1.
- R6: The number of cycles from the last rising clock edge to the strobe rising is at least HOLD_CYC = ceil(HOLD_PS / CLK_PS), with a minimum of 1.
- R7: `busy_o` equals the inverse of `strobe_n_o`. A `start_i` or `zero_i` seen while busy is ignored, and the word in flight goes out unchanged.
- R8: `done_o` is 1 for exactly one cycle, the first cycle in which `strobe_n_o` is back at 1. A request seen in that cycle is accepted.
- R9: `zero_i` alone writes the all-zero word. When `start_i` and `zero_i` are both 1, `start_i` wins and `word_i` is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to write `word_i` |
| word_i | input | WORD_W | Word to write, sampled with `start_i` |
| zero_i | input | 1 | Request to write the all-zero word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the strobe returns high |
| strobe_n_o | output | 1 | Active-low frame strobe |
| sclk_o | output | 1 | Serial clock, idles high, receiver samples on its rising edge |
| sdata_o | output | 1 | Serial data, most significant bit first |

## Verification
The bench builds the block with a 8000 ps clock period, a 75000 ps setup gap and a 250000 ps hold gap. These round up to gaps of 10 and 32 cycles, so a rounding-down error shows in the strobe length. The half-periods are set to 2 low and 3 high cycles, so a swapped or shortened phase changes the expected waveform. The frame is 122 cycles long, which leaves room to fire requests mid-frame, in the done cycle, and with both request inputs high at once.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;
endpackage

// File: rtl/ssw_rst_sync.sv
module ssw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ssw_phase_timer.sv
module ssw_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = load_val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ssw_shifter.sv
module ssw_shifter #(
  parameter int WORD_W = 16,
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load_i) begin
      sh_d   = word_i;
      left_d = BIT_W'(WORD_W - 1);
    end else if (shift_i) begin
      sh_d   = {sh_q[WORD_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign msb_o  = sh_q[WORD_W-1];
  assign last_o = (left_q == '0);
endmodule

// File: rtl/slot_select_writer.sv
module slot_select_writer
  import ssw_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CLK_PS     = 8000,
  parameter int SETUP_PS   = 75000,
  parameter int HOLD_PS    = 250000,
  parameter int CLK_LO_CYC = 2,
  parameter int CLK_HI_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              zero_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              strobe_n_o,
  output logic              sclk_o,
  output logic              sdata_o
);
  localparam int SETUP_RAW = (SETUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_RAW  = (HOLD_PS + CLK_PS - 1) / CLK_PS;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int LO_CYC    = (CLK_LO_CYC < 1) ? 1 : CLK_LO_CYC;
  localparam int HI_CYC    = (CLK_HI_CYC < 1) ? 1 : CLK_HI_CYC;
  localparam int CNT_W     = $clog2(SETUP_CYC + HOLD_CYC + LO_CYC + HI_CYC + 1);

  logic              rst_n_s;
  phase_e            state_q, state_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              sh_load, sh_shift, sh_msb, sh_last;
  logic [WORD_W-1:0] sh_word;
  logic              done_q, done_d;
  logic              strobe_n_q, sclk_q;

  ssw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync_o(rst_n_s)
  );

  ssw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  ssw_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk(clk), .rst_n(rst_n_s), .load_i(sh_load), .word_i(sh_word),
    .shift_i(sh_shift), .msb_o(sh_msb), .last_o(sh_last)
  );

  // Next-state logic: one shared down-counter times every phase.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_word  = start_i ? word_i : '0;
    done_d   = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i || zero_i) begin
          state_d  = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
          sh_load  = 1'b1;
        end
      end
      PH_SETUP: begin
        if (tmr_zero) begin
          state_d  = PH_LOW;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LO_CYC - 1);
        end
      end
      PH_LOW: begin
        if (tmr_zero) begin
          state_d  = PH_HIGH;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HI_CYC - 1);
        end
      end
      PH_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (sh_last) begin
            state_d = PH_HOLD;
            tmr_val = CNT_W'(HOLD_CYC - 1);
          end else begin
            state_d  = PH_LOW;
            tmr_val  = CNT_W'(LO_CYC - 1);
            sh_shift = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (tmr_zero) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // Register process: line outputs come straight from flops.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= PH_IDLE;
      done_q     <= 1'b0;
      strobe_n_q <= 1'b1;
      sclk_q     <= 1'b1;
    end else begin
      state_q    <= state_d;
      done_q     <= done_d;
      strobe_n_q <= (state_d == PH_IDLE);
      sclk_q     <= (state_d != PH_LOW);
    end
  end

  assign busy_o     = ~strobe_n_q;
  assign done_o     = done_q;
  assign strobe_n_o = strobe_n_q;
  assign sclk_o     = sclk_q;
  assign sdata_o    = sh_msb;
endmodule

// File: rtl/slot_select_writer_chk.sv
module slot_select_writer_chk #(
  parameter int WORD_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic zero_i,
  input logic busy_o,
  input logic done_o,
  input logic strobe_n_o,
  input logic sclk_o,
  input logic sdata_o
);
  logic [15:0] rises_q, low_cnt_q, gap_q;
  logic        sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q     <= '0;
      low_cnt_q   <= '0;
      gap_q       <= '0;
      sclk_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_o;
      if (strobe_n_o) begin
        rises_q   <= '0;
        low_cnt_q <= '0;
      end else begin
        if (sclk_o && !sclk_prev_q) rises_q <= rises_q + 1'b1;
        if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
      end
      if (sclk_o && !sclk_prev_q) gap_q <= 16'd1;
      else if (!strobe_n_o && gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (strobe_n_o && sclk_o));
  // R2
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (start_i || zero_i)) |=> !strobe_n_o);
  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n_o) |-> (rises_q == 16'(WORD_W)));
  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && !strobe_n_o) |-> $stable(sdata_o));
  // R5
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && !strobe_n_o && rises_q == '0) |-> (low_cnt_q >= 16'(SETUP_CYC)));
  // R6
  hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n_o) |-> (gap_q >= 16'(HOLD_CYC)));
  // R7
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == !strobe_n_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == $rose(strobe_n_o));
endmodule

bind slot_select_writer slot_select_writer_chk #(
  .WORD_W(WORD_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .zero_i(zero_i),
  .busy_o(busy_o), .done_o(done_o), .strobe_n_o(strobe_n_o),
  .sclk_o(sclk_o), .sdata_o(sdata_o)
);

// File: tb/test_slot_select_writer.sv
module test_slot_select_writer;
  localparam int WORD_W   = 16;
  localparam int CLK_PS   = 8000;
  localparam int SETUP_PS = 75000;
  localparam int HOLD_PS  = 250000;
  localparam int LO       = 2;
  localparam int HI       = 3;
  localparam int SETUP_N  = (SETUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_N   = (HOLD_PS + CLK_PS - 1) / CLK_PS;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic zero_i = 1'b0;
  logic [WORD_W-1:0] word_i = '0;
  logic busy_o, done_o, strobe_n_o, sclk_o, sdata_o;

  always #4ns clk = ~clk;

  slot_select_writer #(
    .WORD_W(WORD_W), .CLK_PS(CLK_PS), .SETUP_PS(SETUP_PS),
    .HOLD_PS(HOLD_PS), .CLK_LO_CYC(LO), .CLK_HI_CYC(HI)
  ) i_slot_select_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .zero_i(zero_i), .busy_o(busy_o), .done_o(done_o),
    .strobe_n_o(strobe_n_o), .sclk_o(sclk_o), .sdata_o(sdata_o)
  );

  typedef struct {
    logic fn; logic sc; logic sd; logic sdv; logic bz; logic dn;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0;
  int fails = 0;
  int frames_sent = 0;
  logic finished = 1'b0;

  function automatic exp_t mk(logic fn, logic sc, logic sd, logic sdv, logic bz, logic dn);
    exp_t e;
    e.fn = fn; e.sc = sc; e.sd = sd; e.sdv = sdv; e.bz = bz; e.dn = dn;
    return e;
  endfunction

  // Reference model: builds the whole frame waveform when a request is accepted.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = mk(1, 1, 0, 0, 0, 0);
    end else begin
      if (q.size() == 0 && (start_i || zero_i)) begin
        logic [WORD_W-1:0] w;
        w = start_i ? word_i : '0;          // R9: start wins over zero
        frames_sent++;
        for (int i = 0; i < SETUP_N; i++) q.push_back(mk(0, 1, 0, 0, 1, 0));
        for (int b = WORD_W - 1; b >= 0; b--) begin
          for (int i = 0; i < LO; i++) q.push_back(mk(0, 0, w[b], 1, 1, 0));
          for (int i = 0; i < HI; i++) q.push_back(mk(0, 1, w[b], 1, 1, 0));
        end
        for (int i = 0; i < HOLD_N; i++) q.push_back(mk(0, 1, 0, 0, 1, 0));
        q.push_back(mk(1, 1, 0, 0, 0, 1));
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = mk(1, 1, 0, 0, 0, 0);
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (strobe_n_o !== cur.fn) begin
        fails++;
        $display("FAIL R2/R5/R6 strobe_n_o: actual %b expected %b at %0t", strobe_n_o, cur.fn, $time);
      end else if (sclk_o !== cur.sc) begin
        fails++;
        $display("FAIL R3 sclk_o: actual %b expected %b at %0t", sclk_o, cur.sc, $time);
      end else if (cur.sdv && sdata_o !== cur.sd) begin
        fails++;
        $display("FAIL R4 sdata_o: actual %b expected %b at %0t", sdata_o, cur.sd, $time);
      end else if (busy_o !== cur.bz) begin
        fails++;
        $display("FAIL R7 busy_o: actual %b expected %b at %0t", busy_o, cur.bz, $time);
      end else if (done_o !== cur.dn) begin
        fails++;
        $display("FAIL R8 done_o: actual %b expected %b at %0t", done_o, cur.dn, $time);
      end else if (!rst_n && (strobe_n_o !== 1'b1 || sclk_o !== 1'b1 || busy_o !== 1'b0)) begin
        fails++;
        $display("FAIL R1 reset state: actual %b%b%b expected 110 at %0t", strobe_n_o, sclk_o, busy_o, $time);
      end
    end
  end

  task automatic pulse(input logic st, input logic zr, input logic [WORD_W-1:0] w);
    @(negedge clk);
    start_i = st; zero_i = zr; word_i = w;
    @(negedge clk);
    start_i = 1'b0; zero_i = 1'b0; word_i = ~w;
  endtask

  task automatic wait_idle();
    while (busy_o !== 1'b0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);               // R1: reset state compared each cycle
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    pulse(1, 0, 16'hA5C3);                   // R2 R3 R4 R5 R6: mixed pattern
    wait_idle();

    pulse(1, 0, 16'h1234);                   // R7: mid-frame requests ignored
    repeat (40) @(negedge clk);
    pulse(1, 0, 16'hFFFF);
    pulse(0, 1, 16'h0000);
    wait_idle();

    pulse(1, 0, 16'h8001);                   // R8: back-to-back in the done cycle
    while (done_o !== 1'b1) @(negedge clk);
    start_i = 1'b1; word_i = 16'h7FFE;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    pulse(0, 1, 16'hBEEF);                   // R9: zero request writes all zeros
    wait_idle();

    pulse(1, 1, 16'hC00D);                   // R9: start wins over zero
    wait_idle();

    pulse(1, 0, 16'hFFFF);                   // R4: all ones
    wait_idle();

    checks++;                                // R8: every request produced exactly one frame
    if (frames_sent != 7) begin
      fails++;
      $display("FAIL R8 frame count: actual %0d expected 7", frames_sent);
    end
    finish_run();
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      finish_run();
    end
  end
endmodule